// File: doc/BRIEF.md
# Shared-Datapath AES Column Mixer

This block applies the AES column mixing step to one 32-bit column of four bytes, in either direction. A single mode input selects the forward transform or its inverse. The forward transform multiplies the column polynomial by {03}x^3 + {01}x^2 + {01}x + {02} modulo x^4 + 1. The inverse multiplies it by {0b}x^3 + {0d}x^2 + {09}x + {0e} modulo x^4 + 1.

The inverse has no multipliers of its own for {09}, {0b}, {0d} and {0e}. A small folding stage in front of the forward network builds the inverse instead. It forms u = {04}(a0 ^ a2) and v = {04}(a1 ^ a3), and XORs u into rows 0 and 2 and v into rows 1 and 3. Each {04} product is two doubling steps in series. In forward mode the folding stage passes the column through unchanged. The mixed column is then registered. To cover a full 128-bit state, instantiate the block four times.

Top module: `col_mixer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `col_out` becomes 32'h00000000 after that edge.
- R2: With `rst` low, `col_out` after a rising edge is the transform of the `col_in` and `inv_mode` values sampled at that edge. The latency is exactly one cycle.
- R3: With `inv_mode` = 0, the block computes the forward mix. Row 0 of the column is bits [31:24] and row 3 is bits [7:0]. Column 32'hdb135345 gives 32'h8e4da1bc, and column 32'hf20a225c gives 32'h9fdc589d.
- R4: With `inv_mode` = 1, the block computes the inverse mix, using the same byte layout as R3. Column 32'h8e4da1bc gives 32'hdb135345, and column 32'h9fdc589d gives 32'hf20a225c.
- R5: For any column c, applying the inverse to the forward result of c returns c.
- R6: A column whose four bytes are all equal comes out unchanged in both modes. For example, 32'hc6c6c6c6 gives 32'hc6c6c6c6 and 32'h01010101 gives 32'h01010101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inv_mode | input | 1 | 0 selects the forward mix, 1 selects the inverse mix |
| col_in | input | 32 | Input column, row 0 in bits [31:24] |
| col_out | output | 32 | Registered mixed column, same byte layout as col_in |

## Verification
Published column vectors are applied in both directions. They fix the byte order and the constant for each row, which a reflected or rotated wiring would get wrong. Uniform columns return themselves only when each row's coefficients sum to {01}, so they isolate the coefficient sets. Random columns are sent forward and then fed back in inverse mode, and the mode bit is toggled on every cycle. This exposes a fault in the folding stage and any stale-mode timing error. Every cycle is also compared against a behavioural multiply-and-sum model.

// File: rtl/colmix_pkg.sv
package colmix_pkg;
  localparam int BYTE_W = 8;
  localparam int ROWS   = 4;
  localparam int COL_W  = BYTE_W * ROWS;
  localparam logic [BYTE_W-1:0] REDUCE_POLY = 8'h1B;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [ROWS-1:0]  col_arr_t;

  // multiply by {02} in the AES field
  function automatic byte_t dbl(input byte_t a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? REDUCE_POLY : '0);
  endfunction

  // row r sits at bits [COL_W-1-BYTE_W*r -: BYTE_W]
  function automatic col_arr_t unpack_col(input logic [COL_W-1:0] v);
    col_arr_t r;
    for (int i = 0; i < ROWS; i++) r[i] = v[COL_W-1-BYTE_W*i -: BYTE_W];
    return r;
  endfunction

  function automatic logic [COL_W-1:0] pack_col(input col_arr_t c);
    logic [COL_W-1:0] v;
    for (int i = 0; i < ROWS; i++) v[COL_W-1-BYTE_W*i -: BYTE_W] = c[i];
    return v;
  endfunction
endpackage

// File: rtl/col_fold.sv
module col_fold
  import colmix_pkg::*;
(
  input  logic     inv_mode,
  input  col_arr_t col_i,
  output col_arr_t col_o
);
  localparam int HALF = ROWS / 2;

  byte_t pair_sum [HALF];
  byte_t quad     [HALF];

  genvar p, r;
  generate
    for (p = 0; p < HALF; p++) begin : g_pair
      assign pair_sum[p] = col_i[p] ^ col_i[p+HALF];
      assign quad[p]     = dbl(dbl(pair_sum[p]));
    end
    for (r = 0; r < ROWS; r++) begin : g_row
      assign col_o[r] = inv_mode ? (col_i[r] ^ quad[r % HALF]) : col_i[r];
    end
  endgenerate

  // the same correction enters both rows of a pair, so the pair's XOR is preserved
  always_comb begin
    assert_pair_sum_R4: assert ((col_o[0] ^ col_o[HALF]) == (col_i[0] ^ col_i[HALF]))
      else $error("pair sum changed by fold stage");
  end
endmodule

// File: rtl/col_fwd_mix.sv
module col_fwd_mix
  import colmix_pkg::*;
(
  input  col_arr_t col_i,
  output col_arr_t col_o
);
  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      localparam int N1 = (r + 1) % ROWS;
      localparam int N2 = (r + 2) % ROWS;
      localparam int N3 = (r + 3) % ROWS;
      // {02}a + {03}b + c + d = {02}(a^b) ^ b ^ c ^ d
      assign col_o[r] = dbl(col_i[r] ^ col_i[N1]) ^ col_i[N1] ^ col_i[N2] ^ col_i[N3];
    end
  endgenerate

  always_comb begin
    if ((col_i[0] == col_i[1]) && (col_i[1] == col_i[2]) && (col_i[2] == col_i[3]))
      assert_uniform_fixed_R6: assert (col_o == col_i)
        else $error("uniform column altered by forward mix");
  end
endmodule

// File: rtl/col_mixer.sv
module col_mixer
  import colmix_pkg::*;
#(
  parameter int W = COL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inv_mode,
  input  logic [W-1:0] col_in,
  output logic [W-1:0] col_out
);
  col_arr_t col_a, col_f, col_m;
  logic     warm;

  assign col_a = unpack_col(col_in);

  col_fold u_fold (
    .inv_mode (inv_mode),
    .col_i    (col_a),
    .col_o    (col_f)
  );

  col_fwd_mix u_mix (
    .col_i (col_f),
    .col_o (col_m)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_out <= '0;
      warm    <= 1'b0;
    end else begin
      col_out <= pack_col(col_m);
      warm    <= 1'b1;
    end
  end

  assert_rst_clear_R1: assert property (@(posedge clk) rst |=> (col_out == '0))
    else $error("output not cleared by reset");

  assert_zero_in_R3: assert property (@(posedge clk) disable iff (rst)
    (col_in == '0) |=> (col_out == '0))
    else $error("zero column produced nonzero output");

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst || !warm)
    ($stable(col_in) && $stable(inv_mode)) |=> $stable(col_out))
    else $error("output changed with steady inputs");
endmodule

// File: tb/col_mixer_tb.sv
module col_mixer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_mode = 1'b0;
  logic [31:0] col_in = 32'h0;
  logic [31:0] col_out;

  int checks = 0;
  int fails  = 0;

  logic [31:0] pend_exp = 32'h0;
  string       pend_tag = "R1";
  bit          pend_has_k = 1'b0;
  logic [31:0] pend_k = 32'h0;

  always #2 clk = ~clk;

  col_mixer u_dut (
    .clk      (clk),
    .rst      (rst),
    .inv_mode (inv_mode),
    .col_in   (col_in),
    .col_out  (col_out)
  );

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return acc;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] c, input logic inv);
    logic [7:0] a [4];
    logic [7:0] k [4];
    logic [31:0] res;
    for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
    if (inv) begin k[0]=8'h0e; k[1]=8'h0b; k[2]=8'h0d; k[3]=8'h09; end
    else     begin k[0]=8'h02; k[1]=8'h03; k[2]=8'h01; k[3]=8'h01; end
    for (int i = 0; i < 4; i++) begin
      logic [7:0] s = 8'h0;
      for (int j = 0; j < 4; j++) s ^= gmul(a[j], k[(j - i + 4) % 4]);
      res[31-8*i -: 8] = s;
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: col_out=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // compare the previous cycle's prediction, then drive the next inputs
  task automatic tick(input logic [31:0] c, input logic m, input string tag,
                      input bit has_k, input logic [31:0] k);
    @(negedge clk);
    check(pend_tag, col_out, pend_exp);
    if (pend_has_k) check(pend_tag, col_out, pend_k);
    col_in = c; inv_mode = m;
    pend_exp = model(c, m); pend_tag = tag; pend_has_k = has_k; pend_k = k;
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: col_out=%08h expected=done", col_out);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset clears output even with a live input
    col_in = 32'hdb135345;
    @(negedge clk); check("R1", col_out, 32'h0);
    @(negedge clk); check("R1", col_out, 32'h0);
    rst = 1'b0;
    pend_exp = model(col_in, inv_mode); pend_tag = "R2";

    tick(32'hdb135345, 1'b0, "R3", 1, 32'h8e4da1bc);
    tick(32'hf20a225c, 1'b0, "R3", 1, 32'h9fdc589d);
    tick(32'h8e4da1bc, 1'b1, "R4", 1, 32'hdb135345);
    tick(32'h9fdc589d, 1'b1, "R4", 1, 32'hf20a225c);
    tick(32'hc6c6c6c6, 1'b0, "R6", 1, 32'hc6c6c6c6);
    tick(32'hc6c6c6c6, 1'b1, "R6", 1, 32'hc6c6c6c6);
    tick(32'h01010101, 1'b1, "R6", 1, 32'h01010101);
    tick(32'h01010101, 1'b0, "R6", 1, 32'h01010101);
    tick(32'hd4d4d4d5, 1'b0, "R3", 1, 32'hd5d5d7d6);
    tick(32'hd5d5d7d6, 1'b1, "R4", 1, 32'hd4d4d4d5);

    // R5: forward then inverse returns the original column
    for (int n = 0; n < 200; n++) begin
      logic [31:0] c = $urandom;
      tick(c, 1'b0, "R2", 0, 32'h0);
      tick(model(c, 1'b0), 1'b1, "R5", 1, c);
    end

    // R2: mode toggling on every cycle with random data
    for (int n = 0; n < 200; n++) tick($urandom, n[0], "R2", 0, 32'h0);

    // R1: mid-run reset
    @(negedge clk);
    check(pend_tag, col_out, pend_exp);
    col_in = 32'h12345678; rst = 1'b1;
    @(negedge clk); check("R1", col_out, 32'h0);
    rst = 1'b0;
    pend_exp = model(col_in, inv_mode); pend_tag = "R2"; pend_has_k = 0;
    tick(32'h0, 1'b0, "R2", 0, 32'h0);
    @(negedge clk); check(pend_tag, col_out, pend_exp);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule